// File: doc/BRIEF.md
# Packed Halfword Running-Maximum Tracker

This block searches a stream of signed 16-bit samples for the largest value and remembers where it was found. Samples arrive two to a 32-bit word, one word per clock when the valid input is high. Each word is split into halves. The upper half is examined first, and the lower half is then compared against the result of that first step. Whenever a sample beats the stored best, the block records the sample and its element index.

The winner and its index share one 32-bit state word that is always visible on an output. A free-running element counter supplies the indices and can also be read. A clear input restarts the search. A parameter turns the unit into a minimum tracker, but the default build searches for the maximum and is the one specified here.

Top module: `halfMaxTracker`

## Requirements
- R1: After reset, and in the cycle after `clearIn` is high, `stateWord` is 32'h8000_0000 (the best value is the most negative 16-bit number and the index is 0), and `sampleIndex` is 0.
- R2: In an accepted word, the sample in bits 31:16 is taken as the earlier element, with index `sampleIndex`, and is evaluated before the sample in bits 15:0, which takes index `sampleIndex`+1. If both halves are equal and beat the stored best, the upper half's index is recorded.
- R3: `stateWord` bits 31:16 hold the best sample so far, and bits 15:0 hold the element index that sample came from.
- R4: The state changes only when a sample is strictly greater than the stored best. On a tie, the earlier index is kept.
- R5: The lower sample of a word is compared against the best value as already updated by that word's upper sample.
- R6: Every accepted word advances `sampleIndex` by 2, modulo 2^16, whether or not the best value changes.
- R7: Samples are compared as signed two's complement numbers, so 16'h7FFF is the largest value and 16'h8000 is the smallest.
- R8: When `clearIn` and `wordValid` are high in the same cycle, the clear wins and the word is discarded.
- R9: In a cycle with both `wordValid` and `clearIn` low, `stateWord` and `sampleIndex` keep their values.
- R10: The effect of a word accepted at one rising edge can be read on the outputs right after that edge, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clearIn | input | 1 | Restart the search |
| wordValid | input | 1 | `wordData` holds two samples to examine this cycle |
| wordData | input | 32 | Two packed signed samples; bits 31:16 are the earlier element |
| stateWord | output | 32 | Best sample in bits 31:16, its index in bits 15:0 |
| sampleIndex | output | 16 | Index that the next upper-half sample will receive |

## Verification
The assertions assume that `clearIn` and `wordValid` are known values after reset and that any data is allowed, including equal halves and the signed extremes. The assertions make no assumption about the order of inputs. Because of this, the stimulus is free to mix random words, which are sometimes drawn from a narrow range so that ties happen often, with clears, idle cycles and clear-with-valid collisions. Directed words add exact ties, the values 16'h7FFF and 16'h8000, and a case where the lower half beats an upper half that has just won.

// File: rtl/hmt_pkg.sv
package hmt_pkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic clearNow;  // return to the search start state
    logic takeWord;  // examine both halves of wordData
  } hmtStrobes_t;
endpackage

// File: rtl/hmtControl.sv
module hmtControl
  import hmt_pkg::*;
(
  input  logic        clearIn,
  input  logic        wordValid,
  output hmtStrobes_t strobes
);
  // Clear takes priority: a word arriving with it is dropped
  always_comb begin
    strobes.clearNow = clearIn;
    strobes.takeWord = wordValid & ~clearIn;
  end
endmodule

// File: rtl/hmtDatapath.sv
module hmtDatapath
  import hmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter bit FIND_MIN = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hmtStrobes_t           strobes,
  input  logic [2*SAMPLE_W-1:0] wordData,
  output logic [2*SAMPLE_W-1:0] stateWord,
  output logic [SAMPLE_W-1:0]   sampleIndex
);
  localparam int WORD_W = 2 * SAMPLE_W;
  // Start value loses against any sample
  localparam logic [SAMPLE_W-1:0] START_BEST = FIND_MIN ?
    {1'b0, {(SAMPLE_W-1){1'b1}}} : {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] bestVal, bestIdx, countReg;
  logic [SAMPLE_W-1:0] hiSample, loSample;
  logic [SAMPLE_W-1:0] midVal, midIdx, endVal, endIdx;
  logic                hiWins, loWins;

  assign hiSample = wordData[WORD_W-1:SAMPLE_W];
  assign loSample = wordData[SAMPLE_W-1:0];

  // Strict comparison picked by the search direction
  generate
    if (FIND_MIN) begin : g_min
      assign hiWins = $signed(hiSample) < $signed(bestVal);
      assign loWins = $signed(loSample) < $signed(midVal);
    end else begin : g_max
      assign hiWins = $signed(hiSample) > $signed(bestVal);
      assign loWins = $signed(loSample) > $signed(midVal);
    end
  endgenerate

  // Upper half first, lower half against the updated best
  always_comb begin
    midVal = hiWins ? hiSample : bestVal;
    midIdx = hiWins ? countReg : bestIdx;
    endVal = loWins ? loSample : midVal;
    endIdx = loWins ? countReg + SAMPLE_W'(1) : midIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestVal  <= START_BEST;
      bestIdx  <= '0;
      countReg <= '0;
    end else if (strobes.clearNow) begin
      bestVal  <= START_BEST;
      bestIdx  <= '0;
      countReg <= '0;
    end else if (strobes.takeWord) begin
      bestVal  <= endVal;
      bestIdx  <= endIdx;
      countReg <= countReg + SAMPLE_W'(2);
    end
  end

  assign stateWord   = {bestVal, bestIdx};
  assign sampleIndex = countReg;
endmodule

// File: rtl/halfMaxTracker.sv
module halfMaxTracker
  import hmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter bit FIND_MIN = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clearIn,
  input  logic                  wordValid,
  input  logic [2*SAMPLE_W-1:0] wordData,
  output logic [2*SAMPLE_W-1:0] stateWord,
  output logic [SAMPLE_W-1:0]   sampleIndex
);
  hmtStrobes_t strobes;

  hmtControl i_ctrl (
    .clearIn  (clearIn),
    .wordValid(wordValid),
    .strobes  (strobes)
  );

  hmtDatapath #(.SAMPLE_W(SAMPLE_W), .FIND_MIN(FIND_MIN)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wordData   (wordData),
    .stateWord  (stateWord),
    .sampleIndex(sampleIndex)
  );
endmodule

// File: rtl/hmtChecker.sv
module hmtChecker #(
  parameter int SAMPLE_W = 16,
  parameter bit FIND_MIN = 1'b0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clearIn,
  input logic                  wordValid,
  input logic [2*SAMPLE_W-1:0] wordData,
  input logic [2*SAMPLE_W-1:0] stateWord,
  input logic [SAMPLE_W-1:0]   sampleIndex
);
  localparam logic [SAMPLE_W-1:0] START_BEST = FIND_MIN ?
    {1'b0, {(SAMPLE_W-1){1'b1}}} : {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] curBest, curIdx;
  assign curBest = stateWord[2*SAMPLE_W-1:SAMPLE_W];
  assign curIdx  = stateWord[SAMPLE_W-1:0];

  // R1 and R8: a clear restores the start state, even with valid high
  a_r1_clear_state: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (curBest == START_BEST && curIdx == '0 && sampleIndex == '0));

  // R6: each accepted word advances the counter by two
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !clearIn) |=> sampleIndex == $past(sampleIndex) + SAMPLE_W'(2));

  // R9: idle cycles hold everything
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wordValid && !clearIn) |=> ($stable(stateWord) && $stable(sampleIndex)));

  // R4: the best value never gets worse while words are accepted
  a_r4_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !clearIn) |=>
      ((!FIND_MIN && $signed(curBest) >= $signed($past(curBest))) ||
       ( FIND_MIN && $signed(curBest) <= $signed($past(curBest)))));

  // R4: an unchanged best value keeps its earlier index
  a_r4_tie_keeps_index: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !clearIn) |=>
      (curBest != $past(curBest) || curIdx == $past(curIdx)));

  // R2, R3: a new index belongs to one of the two samples of the word
  a_r3_index_from_word: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !clearIn) |=>
      (curIdx == $past(curIdx) || curIdx == $past(sampleIndex) ||
       curIdx == $past(sampleIndex) + SAMPLE_W'(1)));
endmodule

bind halfMaxTracker hmtChecker #(.SAMPLE_W(SAMPLE_W), .FIND_MIN(FIND_MIN)) i_hmtChecker (
  .clk        (clk),
  .rstN       (rstN),
  .clearIn    (clearIn),
  .wordValid  (wordValid),
  .wordData   (wordData),
  .stateWord  (stateWord),
  .sampleIndex(sampleIndex)
);

// File: tb/test_halfMaxTracker.sv
`timescale 1ns/1ps
module test_halfMaxTracker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearIn = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic [31:0] stateWord;
  logic [15:0] sampleIndex;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference state, kept from the requirements only
  logic signed [15:0] refBest;
  logic [15:0]        refIdx;
  logic [15:0]        refCnt;

  always #4 clk = ~clk;  // 125 MHz

  halfMaxTracker i_halfMaxTracker (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .wordValid(wordValid),
    .wordData(wordData), .stateWord(stateWord), .sampleIndex(sampleIndex)
  );

  function automatic logic [31:0] expectedState();
    return {refBest, refIdx};
  endfunction

  task automatic refClear();
    refBest = 16'sh8000;
    refIdx  = 16'h0;
    refCnt  = 16'h0;
  endtask

  // R2, R4, R5, R6, R7: upper half first, strict signed compare
  task automatic refWord(input logic [31:0] w);
    logic signed [15:0] hi = w[31:16];
    logic signed [15:0] lo = w[15:0];
    if (hi > refBest) begin refBest = hi; refIdx = refCnt; end
    if (lo > refBest) begin refBest = lo; refIdx = refCnt + 16'd1; end
    refCnt = refCnt + 16'd2;
  endtask

  task automatic checkOut(input string tag);
    checks++;
    if (stateWord !== expectedState() || sampleIndex !== refCnt) begin
      errors++;
      $display("FAIL %s: stateWord=%h sampleIndex=%h expected %h %h",
               tag, stateWord, sampleIndex, expectedState(), refCnt);
    end
  endtask

  // Inputs change at the falling edge; outputs are read at the next falling edge (R10)
  task automatic step(input logic clr, input logic vld, input logic [31:0] w,
                      input string tag);
    clearIn = clr; wordValid = vld; wordData = w;
    @(posedge clk);
    if (clr) refClear();
    else if (vld) refWord(w);
    @(negedge clk);
    clearIn = 1'b0; wordValid = 1'b0;
    checkOut(tag);
  endtask

  function automatic logic [15:0] pickHalf();
    if ($urandom_range(0, 2) == 0) return 16'($urandom);
    return 16'($signed(5'($urandom_range(0, 8))) - 16'sd4);
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    refClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 reset state");

    // R2, R4: equal halves, upper index kept
    step(1'b0, 1'b1, 32'h0005_0005, "R2 equal halves keep upper index");
    // R5, R6: lower half wins, index count+1
    step(1'b0, 1'b1, 32'h0003_0007, "R6 lower index is count plus one");
    // R4: tie with stored best keeps earlier index
    step(1'b0, 1'b1, 32'h0007_0007, "R4 tie keeps earlier index");
    step(1'b0, 1'b1, 32'hFFFF_0001, "R4 smaller samples ignored");
    // R9: idle
    step(1'b0, 1'b0, 32'h7FFF_7FFF, "R9 idle holds state");
    // R1 clear
    step(1'b1, 1'b0, 32'h0, "R1 clear state");
    // R7: signed compare
    step(1'b0, 1'b1, 32'hFFFE_8000, "R7 negative beats start, 8000 smallest");
    step(1'b0, 1'b1, 32'h7FFF_0000, "R7 7FFF largest");
    step(1'b1, 1'b0, 32'h0, "R1 clear again");
    // R5: lower beats freshly updated upper
    step(1'b0, 1'b1, 32'h0001_0002, "R5 lower against updated best");
    step(1'b0, 1'b1, 32'h0009_0003, "R3 value high index low");
    // R8: clear wins over valid
    step(1'b1, 1'b1, 32'h7FFF_7FFF, "R8 clear with valid");

    for (int n = 0; n < 4000; n++) begin
      int pick = $urandom_range(0, 99);
      if (pick < 3)       step(1'b1, $urandom_range(0, 1) == 1, {pickHalf(), pickHalf()}, "R8 random clear");
      else if (pick < 15) step(1'b0, 1'b0, {pickHalf(), pickHalf()}, "R9 random idle");
      else                step(1'b0, 1'b1, {pickHalf(), pickHalf()}, "R6 random word");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule